// File: doc/BRIEF.md
# Power-save phase mode controller

This block turns a three-level power-save request into the operating mode of a two-phase buck control core. The request reaches it as a 2-bit thermometer code from an external window comparator. The code is first synchronised and debounced. The accepted level then selects one of three running modes:

- both phases switching in continuous conduction;
- phase 1 alone in continuous conduction;
- phase 1 alone with diode emulation allowed.

The block sits between the PWM core and the gate drivers. It passes through or blocks each phase's high-side and low-side drive requests. It also tells the core whether diode emulation is on and which switching-frequency setting to use. In diode-emulation mode, a zero-cross indication cuts the phase-1 low-side drive until the next PWM cycle starts.

Mode changes happen while the converter runs, with no restart. A new mode takes effect only on a PWM cycle boundary, so no phase ever receives a truncated pulse. A strap input marks a build with only one phase fitted. In that build a high request is demoted to single-phase continuous mode and a configuration error is flagged. A low enable input parks the block in its off state.

The state machine has four states, reported on `mode_o`:

| State | Code | Phase enables | Diode emulation | Frequency select |
|---|---|---|---|---|
| MODE_OFF | 0 | none | off | 0 |
| MODE_PS0 | 1 | both phases | off | 0 |
| MODE_PS1 | 2 | phase 1 only | off | 1 |
| MODE_PS2 | 3 | phase 1 only | on | 1 |

Transitions:

- **OFF_TO_RUN**: `ctl_en` high and a cycle boundary. Enters the target mode of the accepted level.
- **RUN_RETARGET**: any running state at a cycle boundary. Moves to the current target mode, which may be the same mode.
- **RUN_TO_OFF**: `ctl_en` low, from any running state, on the next clock edge.

Top module: `psave_mode_ctrl`

## Requirements
- R1: An accepted request level of 2'b11 selects MODE_PS0: `ph_en`=2'b11, `de_en`=0, `fsel_hi`=0, `mode_o`=1.
- R2: An accepted request level of 2'b01 (or the out-of-order code 2'b10) selects MODE_PS1: `ph_en`=2'b01, `de_en`=0, `fsel_hi`=1, `mode_o`=2.
- R3: An accepted request level of 2'b00 selects MODE_PS2: `ph_en`=2'b01, `de_en`=1, `fsel_hi`=1, `mode_o`=3.
- R4: In MODE_PS1 and MODE_PS2, `hs_drv[1]` and `ls_drv[1]` stay 0 whatever `hs_req`/`ls_req` are. An enabled phase passes its requests through to its drives.
- R5: The mode changes only on a clock edge where `cyc_bnd` is 1. Between boundaries the mode holds while the accepted level changes, and the converter keeps running.
- R6: In MODE_PS2, a high `zc_det` forces `ls_drv[0]` to 0 at once, and it stays 0 until the edge where `cyc_bnd` is sampled 1. In MODE_PS0 and MODE_PS1, `zc_det` has no effect.
- R7: With `single_phase_cfg`=1, an accepted level 2'b11 selects MODE_PS1 at the next boundary, and `cfg_err` is 1 while the level is accepted high and the strap is set.
- R8: The request goes through a two-flop synchroniser and a stability filter. A new level must be held for at least `hold_len`+2 clock cycles (plus two cycles of synchroniser latency) before it is accepted. A level held for `hold_len` cycles or fewer is ignored.
- R9: When `ctl_en` is low, the next clock edge takes the state to MODE_OFF with all phase enables and drives 0. After `ctl_en` rises, the mode is entered at the next boundary.
- R10: After reset the state is MODE_OFF with all outputs 0, and the accepted level is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| req_lvl | input | 2 | Raw thermometer request code (00 low, 01 mid, 11 high) |
| single_phase_cfg | input | 1 | Strap for a build with only phase 1 fitted |
| hold_len | input | CNT_W | Stability filter length in cycles |
| cyc_bnd | input | 1 | One-cycle pulse at each PWM cycle start |
| zc_det | input | 1 | Phase-1 inductor current zero-cross indication |
| hs_req | input | 2 | High-side drive requests from the PWM core, one bit per phase |
| ls_req | input | 2 | Low-side drive requests from the PWM core, one bit per phase |
| hs_drv | output | 2 | Gated high-side drives |
| ls_drv | output | 2 | Gated low-side drives |
| ph_en | output | 2 | Per-phase PWM enables |
| de_en | output | 1 | Diode emulation enable |
| fsel_hi | output | 1 | Selects the single-phase (higher) frequency setting |
| mode_o | output | 2 | Current state code (0 off, 1 PS0, 2 PS1, 3 PS2) |
| cfg_err | output | 1 | High request seen on a single-phase build |

## Verification
The assertions check the following on every cycle:

- phase 2 is silent in both single-phase states;
- the state never moves off a boundary while enabled;
- a zero-cross in diode-emulation mode never leaves the phase-1 low-side drive on;
- the strap never lets a boundary land in MODE_PS0;
- disabling always reaches the off state a cycle later;
- the filter only ever accepts its current candidate.

The bench scenarios are needed for the rest:

- the debounce length, where a glitch of `hold_len` cycles is rejected and a longer hold is accepted;
- the zero-cross cut lasting exactly up to the next boundary;
- the mapping of every request code, with and without the strap, to the full output set.

// File: rtl/psave_pkg.sv
package psave_pkg;

    localparam int NPH = 2;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_PS0 = 2'd1,
        MODE_PS1 = 2'd2,
        MODE_PS2 = 2'd3
    } pmode_e;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b11;

    function automatic pmode_e lvl_to_mode(input logic [1:0] lvl, input logic single_cfg);
        pmode_e m;
        unique case (lvl)
            LVL_HIGH: m = single_cfg ? MODE_PS1 : MODE_PS0;
            LVL_LOW:  m = MODE_PS2;
            default:  m = MODE_PS1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/psm_req_filter.sv
module psm_req_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_raw,
    input  logic [CNT_W-1:0] hold_len,
    output logic [1:0]       lvl_acc
);
    logic [1:0]       sync_q1, sync_q2;
    logic [1:0]       cand_q;
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q1 <= 2'b00;
            sync_q2 <= 2'b00;
        end else begin
            sync_q1 <= req_raw;
            sync_q2 <= sync_q1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q  <= 2'b00;
            run_cnt <= '0;
            lvl_acc <= 2'b00;
        end else if (sync_q2 != cand_q) begin
            cand_q  <= sync_q2;
            run_cnt <= '0;
        end else if (run_cnt < hold_len) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            lvl_acc <= cand_q;
        end
    end

    // R8
    acc_from_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_acc != $past(lvl_acc)) |-> (lvl_acc == $past(cand_q)));

endmodule

// File: rtl/psm_mode_fsm.sv
module psm_mode_fsm
    import psave_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_en,
    input  logic           cyc_bnd,
    input  logic [1:0]     lvl_acc,
    input  logic           single_cfg,
    output pmode_e         state,
    output logic [NPH-1:0] ph_en,
    output logic           de_en,
    output logic           fsel_hi
);
    pmode_e state_nx;
    pmode_e target;

    always_comb target = lvl_to_mode(lvl_acc, single_cfg);

    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_OFF: begin
                if (ctl_en && cyc_bnd) state_nx = target;
            end
            MODE_PS0, MODE_PS1, MODE_PS2: begin
                if (!ctl_en)      state_nx = MODE_OFF;
                else if (cyc_bnd) state_nx = target;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        ph_en   = '0;
        de_en   = 1'b0;
        fsel_hi = 1'b0;
        unique case (state)
            MODE_OFF: ;
            MODE_PS0: ph_en = '1;
            MODE_PS1: begin
                ph_en[0] = 1'b1;
                fsel_hi  = 1'b1;
            end
            MODE_PS2: begin
                ph_en[0] = 1'b1;
                de_en    = 1'b1;
                fsel_hi  = 1'b1;
            end
        endcase
    end

    // R5
    bnd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_en) && !$past(cyc_bnd)) |-> $stable(state));

    // R9
    off_when_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (state == MODE_OFF));

endmodule

// File: rtl/psm_drive_gate.sv
module psm_drive_gate #(
    parameter int NPH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cyc_bnd,
    input  logic [NPH-1:0] ph_en,
    input  logic           de_en,
    input  logic           zc_det,
    input  logic [NPH-1:0] hs_req,
    input  logic [NPH-1:0] ls_req,
    output logic [NPH-1:0] hs_drv,
    output logic [NPH-1:0] ls_drv
);
    logic zc_blk;
    logic zc_cut;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          zc_blk <= 1'b0;
        else if (cyc_bnd)                    zc_blk <= 1'b0;
        else if (de_en && zc_det && ls_req[0]) zc_blk <= 1'b1;
    end

    always_comb zc_cut = de_en && (zc_det || zc_blk);

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        always_comb hs_drv[i] = hs_req[i] && ph_en[i];
        if (i == 0) begin : g_zc
            always_comb ls_drv[i] = ls_req[i] && ph_en[i] && !zc_cut;
        end else begin : g_plain
            always_comb ls_drv[i] = ls_req[i] && ph_en[i];
        end
    end

endmodule

// File: rtl/psave_mode_ctrl.sv
module psave_mode_ctrl
    import psave_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic [1:0]       req_lvl,
    input  logic             single_phase_cfg,
    input  logic [CNT_W-1:0] hold_len,
    input  logic             cyc_bnd,
    input  logic             zc_det,
    input  logic [1:0]       hs_req,
    input  logic [1:0]       ls_req,
    output logic [1:0]       hs_drv,
    output logic [1:0]       ls_drv,
    output logic [1:0]       ph_en,
    output logic             de_en,
    output logic             fsel_hi,
    output logic [1:0]       mode_o,
    output logic             cfg_err
);
    logic [1:0] lvl_acc;
    pmode_e     state;

    psm_req_filter #(.CNT_W(CNT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .req_raw(req_lvl), .hold_len(hold_len), .lvl_acc(lvl_acc)
    );

    psm_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .cyc_bnd(cyc_bnd), .lvl_acc(lvl_acc),
        .single_cfg(single_phase_cfg), .state(state), .ph_en(ph_en), .de_en(de_en),
        .fsel_hi(fsel_hi)
    );

    psm_drive_gate #(.NPH(NPH)) u_gate (
        .clk(clk), .rst_n(rst_n), .cyc_bnd(cyc_bnd), .ph_en(ph_en), .de_en(de_en),
        .zc_det(zc_det), .hs_req(hs_req), .ls_req(ls_req), .hs_drv(hs_drv), .ls_drv(ls_drv)
    );

    always_comb mode_o  = state;
    always_comb cfg_err = single_phase_cfg && (lvl_acc == LVL_HIGH);

    // R4
    ph2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_PS1 || state == MODE_PS2) |-> (!hs_drv[1] && !ls_drv[1]));

    // R6
    zc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_PS2 && zc_det) |-> !ls_drv[0]);

    // R7
    strap_no_ps0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_phase_cfg && cyc_bnd) |=> (state != MODE_PS0));

endmodule

// File: tb/test_psave_mode_ctrl.sv
module test_psave_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_en = 1'b0;
    logic [1:0] req_lvl = 2'b00;
    logic       single_phase_cfg = 1'b0;
    logic [7:0] hold_len = 8'd4;
    logic       cyc_bnd = 1'b0;
    logic       zc_det = 1'b0;
    logic [1:0] hs_req = 2'b00;
    logic [1:0] ls_req = 2'b00;
    logic [1:0] hs_drv, ls_drv, ph_en, mode_o;
    logic       de_en, fsel_hi, cfg_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    psave_mode_ctrl i_psave_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .req_lvl(req_lvl),
        .single_phase_cfg(single_phase_cfg), .hold_len(hold_len), .cyc_bnd(cyc_bnd),
        .zc_det(zc_det), .hs_req(hs_req), .ls_req(ls_req), .hs_drv(hs_drv), .ls_drv(ls_drv),
        .ph_en(ph_en), .de_en(de_en), .fsel_hi(fsel_hi), .mode_o(mode_o), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    function automatic logic [1:0] exp_mode(input logic [1:0] lvl, input logic cfg);
        if (lvl == 2'b11) return cfg ? 2'd2 : 2'd1;
        if (lvl == 2'b00) return 2'd3;
        return 2'd2;
    endfunction

    function automatic logic [1:0] exp_phen(input logic [1:0] m);
        return (m == 2'd1) ? 2'b11 : (m == 2'd0) ? 2'b00 : 2'b01;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary();
        cyc_bnd = 1'b1;
        @(negedge clk);
        cyc_bnd = 1'b0;
    endtask

    task automatic check_mode(input string req, input logic [1:0] m);
        check(req, mode_o, m);
        check(req, ph_en, exp_phen(m));
        check(req, de_en, m == 2'd3);
        check(req, fsel_hi, m >= 2'd2);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [1:0] cur;
        cycles(3);
        // R10 reset state
        check("R10 mode", mode_o, 2'd0);
        check("R10 phen", ph_en, 2'b00);
        check("R10 drv", {hs_drv, ls_drv}, 4'h0);
        check("R10 cfg_err", cfg_err, 1'b0);
        rst_n = 1'b1;
        cycles(2);

        // R9 enable waits for boundary
        ctl_en = 1'b1; req_lvl = 2'b11;
        cycles(14);
        check("R9 wait bnd", mode_o, 2'd0);
        boundary();
        check_mode("R1 PS0", 2'd1);

        // R5 hold between boundaries
        req_lvl = 2'b01;
        cycles(14);
        check("R5 held", mode_o, 2'd1);
        hs_req = 2'b11; ls_req = 2'b11; #1;
        check("R4 PS0 pass", {hs_drv, ls_drv}, 4'hF);
        boundary();
        check_mode("R2 PS1", 2'd2);
        #1;
        check("R4 ph2 off PS1", {hs_drv, ls_drv}, 4'b0101);

        req_lvl = 2'b00;
        cycles(14);
        boundary();
        check_mode("R3 PS2", 2'd3);
        #1;
        check("R4 ph2 off PS2", {hs_drv, ls_drv}, 4'b0101);

        // R8 glitch of hold_len cycles ignored
        req_lvl = 2'b11;
        cycles(4);
        req_lvl = 2'b00;
        cycles(14);
        boundary();
        check("R8 glitch ignored", mode_o, 2'd3);
        // R8 long hold accepted
        req_lvl = 2'b11;
        cycles(10);
        req_lvl = 2'b00;
        boundary();
        check("R8 hold accepted", mode_o, 2'd1);
        cycles(14);
        boundary();
        check("R8 back to low", mode_o, 2'd3);

        // R6 zero-cross cut in PS2
        hs_req = 2'b00; ls_req = 2'b01;
        zc_det = 1'b1; #1;
        check("R6 immediate cut", ls_drv[0], 1'b0);
        @(negedge clk);
        zc_det = 1'b0; #1;
        check("R6 cut held", ls_drv[0], 1'b0);
        cycles(3); #1;
        check("R6 cut held late", ls_drv[0], 1'b0);
        boundary(); #1;
        check("R6 released at bnd", ls_drv[0], 1'b1);

        // R6 no effect in PS1
        req_lvl = 2'b10;
        cycles(14);
        boundary();
        check("R2 code 10", mode_o, 2'd2);
        zc_det = 1'b1; #1;
        check("R6 PS1 ignore", ls_drv[0], 1'b1);
        @(negedge clk);
        zc_det = 1'b0; #1;
        check("R6 PS1 ignore after", ls_drv[0], 1'b1);

        // R7 strap
        single_phase_cfg = 1'b1; req_lvl = 2'b11;
        cycles(14);
        check("R7 cfg_err", cfg_err, 1'b1);
        boundary();
        check_mode("R7 demoted", 2'd2);

        // R9 disable
        ctl_en = 1'b0;
        @(negedge clk); #1;
        check("R9 off", mode_o, 2'd0);
        check("R9 drives off", {ph_en, hs_drv, ls_drv}, 6'h0);
        single_phase_cfg = 1'b0;
        ctl_en = 1'b1;
        cycles(14);
        boundary();
        cur = 2'd1;
        check("R9 re-enter", mode_o, cur);

        // randomised mode sweep
        void'($urandom(32'h5A17));
        for (int it = 0; it < 60; it++) begin
            logic [1:0] lv;
            logic cf;
            lv = 2'($urandom_range(0, 3));
            cf = ($urandom_range(0, 3) == 0);
            req_lvl = lv; single_phase_cfg = cf;
            cycles(14);
            check("R5 rand held", mode_o, cur);
            check("R7 rand cfg_err", cfg_err, cf && lv == 2'b11);
            boundary();
            cur = exp_mode(lv, cf);
            check_mode("R1 R2 R3 rand mode", cur);
            for (int k = 0; k < 4; k++) begin
                hs_req = 2'($urandom_range(0, 3));
                ls_req = 2'($urandom_range(0, 3));
                #1;
                check("R4 rand hs", hs_drv, hs_req & exp_phen(cur));
                check("R4 rand ls", ls_drv, ls_req & exp_phen(cur));
                @(negedge clk);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule